// File: doc/BRIEF.md
# Rotating Multi-Bank Sample Capture Buffer

This block takes a stream of ADC words and spreads them over four on-chip memory banks used in turn. One byte-address counter moves forward by four on each accepted sample. Its top two bits pick the bank that is written and the bits below them give the word address inside that bank. Each bank holds 4096 words of 32 bits, which is 16 kB.

When the last word of a bank has been written, the next sample goes to word 0 of the following bank. The block then raises a sticky interrupt and records which bank has just filled, so software can read that bank while the other three fill. After bank 3 the counter wraps to bank 0. No sample is skipped at a bank boundary or at the wrap. If a bank fills while the previous interrupt has not been cleared, an overrun flag is set. That flag means software is about to lose data.

Sampling runs at a nominal 5 MHz on the system clock. A strobe input qualifies each sample, and an enable input can pause capture without losing the position.

Top module: `adc_bank_capture`

## Requirements
- R1: A sample is accepted at a rising clock edge when both `cap_en` and `smp_valid` are 1. It appears on `bank_wdata` unchanged in the cycle after that edge, together with its write enable and address.
- R2: The byte counter is 16 bits wide and moves forward by 4 per accepted sample. `bank_addr` is counter bits [13:2] and the bank index is counter bits [15:14]. The first sample after reset goes to bank 0, word 0, and back-to-back samples use consecutive word addresses.
- R3: For each accepted sample, exactly one bit of `bank_we` is 1, and its position equals the bank index. In a cycle that carries no write, `bank_we` is all zero.
- R4: The sample after word 4095 of bank k is written to word 0 of bank (k+1) mod 4. After bank 3 this is bank 0, and no sample is lost.
- R5: When word 4095 of a bank is written, `irq` becomes 1 in the same cycle as that write appears on the port. In that cycle `done_bank` shows the index of the bank that has just filled.
- R6: `irq` stays at 1 until a cycle with `irq_clr`=1, and it reads 0 after that edge. If a bank fills in the same cycle as a clear, `irq` stays at 1.
- R7: `overrun` becomes 1 when a bank fills while `irq` is 1 and `irq_clr` is 0. It then stays at 1 until a cycle with `ovr_clr`=1.
- R8: When the synchronous reset `rst` is 1, the counter returns to bank 0 word 0, and `irq`, `overrun`, `done_bank` and `bank_we` are cleared.
- R9: While `cap_en` or `smp_valid` is 0, no bank is written and the counter holds its value. Capture then resumes at the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_en | input | 1 | Capture enable; when 0, the counter holds |
| smp_valid | input | 1 | Strobe for one ADC sample |
| smp_data | input | 32 | ADC sample word |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| bank_we | output | 4 | One-hot write enable, one bit per bank |
| bank_addr | output | 12 | Word address inside the selected bank |
| bank_wdata | output | 32 | Write data shared by all banks |
| irq | output | 1 | Sticky flag: a bank has filled |
| done_bank | output | 2 | Index of the most recently filled bank |
| overrun | output | 1 | Sticky flag: a bank filled before the interrupt was cleared |

## Verification
Any fault in the counter shows up on the write port one cycle after the sample that uncovers it. A skipped or repeated word breaks the one-step run of `bank_addr`. A wrong bank decode lights the wrong bit of `bank_we`, or more than one bit. A fault at a bank boundary shows about 4096 samples later: `irq` rises at the wrong sample, or `done_bank` names the wrong bank. The bench compares every write cycle with its own counter model, so such a fault is caught in the first cycle it occurs. A fault in the flag logic shows the next time `irq` or `overrun` is set, held or cleared.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
   localparam int unsigned CAP_DATA_W     = 32;
   localparam int unsigned CAP_NUM_BANKS  = 4;
   localparam int unsigned CAP_BANK_WORDS = 4096;
   localparam int unsigned CAP_ADDR_W     = 16;
   localparam int unsigned CAP_BYTE_SHIFT = 2;   // 32-bit words, byte counter
endpackage

// File: rtl/adc_cap_addr_gen.sv
module adc_cap_addr_gen
   import adc_cap_pkg::*;
#(
   parameter int unsigned NUM_BANKS  = CAP_NUM_BANKS,
   parameter int unsigned BANK_WORDS = CAP_BANK_WORDS,
   parameter int unsigned ADDR_W     = CAP_ADDR_W,
   localparam int unsigned AW = $clog2(BANK_WORDS),
   localparam int unsigned SW = $clog2(NUM_BANKS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [SW-1:0] cur_bank,
   output logic [AW-1:0] cur_word,
   output logic          last_word
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << CAP_BYTE_SHIFT);

   if (ADDR_W != SW + AW + CAP_BYTE_SHIFT) begin : g_bad_width
      $error("ADDR_W must equal bank bits + word bits + byte shift");
   end
   if ((1 << AW) != BANK_WORDS || (1 << SW) != NUM_BANKS || NUM_BANKS < 2) begin : g_bad_pow2
      $error("BANK_WORDS and NUM_BANKS must be powers of two, NUM_BANKS >= 2");
   end

   logic [ADDR_W-1:0] byte_cnt;

   always_ff @(posedge clk) begin
      if (rst)
         byte_cnt <= '0;
      else if (adv)
         byte_cnt <= byte_cnt + STEP;
   end

   assign cur_bank  = byte_cnt[ADDR_W-1 -: SW];
   assign cur_word  = byte_cnt[CAP_BYTE_SHIFT +: AW];
   assign last_word = &cur_word;
endmodule

// File: rtl/adc_cap_wr_port.sv
module adc_cap_wr_port
   import adc_cap_pkg::*;
#(
   parameter int unsigned DATA_W    = CAP_DATA_W,
   parameter int unsigned NUM_BANKS = CAP_NUM_BANKS,
   parameter int unsigned AW        = 12,
   parameter int unsigned SW        = 2,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 acc,
   input  logic [SW-1:0]        sel_bank,
   input  logic [AW-1:0]        sel_word,
   input  logic [DATA_W-1:0]    din,
   output logic [NUM_BANKS-1:0] we,
   output logic [AW-1:0]        addr,
   output logic [DATA_W-1:0]    wdata
);
   logic [NUM_BANKS-1:0] we_dec;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
      assign we_dec[b] = acc && (sel_bank == SW'(b));
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            we    <= '0;
            addr  <= '0;
            wdata <= '0;
         end else begin
            we <= we_dec;
            if (acc) begin
               addr  <= sel_word;
               wdata <= din;
            end
         end
      end
   end else begin : g_comb
      assign we    = we_dec;
      assign addr  = sel_word;
      assign wdata = din;
   end
endmodule

// File: rtl/adc_cap_irq_ctrl.sv
module adc_cap_irq_ctrl #(
   parameter int unsigned SW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          fill_evt,
   input  logic [SW-1:0] fill_idx,
   input  logic          irq_clr,
   input  logic          ovr_clr,
   output logic          irq,
   output logic [SW-1:0] done_bank,
   output logic          overrun
);
   logic lost;

   assign lost = fill_evt && irq && !irq_clr;

   always_ff @(posedge clk) begin
      if (rst) begin
         irq       <= 1'b0;
         overrun   <= 1'b0;
         done_bank <= '0;
      end else begin
         irq     <= fill_evt || (irq && !irq_clr);
         overrun <= lost || (overrun && !ovr_clr);
         if (fill_evt)
            done_bank <= fill_idx;
      end
   end
endmodule

// File: rtl/adc_bank_capture.sv
module adc_bank_capture
   import adc_cap_pkg::*;
#(
   parameter int unsigned DATA_W     = CAP_DATA_W,
   parameter int unsigned NUM_BANKS  = CAP_NUM_BANKS,
   parameter int unsigned BANK_WORDS = CAP_BANK_WORDS,
   parameter int unsigned ADDR_W     = CAP_ADDR_W,
   parameter bit          REG_OUT    = 1'b1,
   localparam int unsigned AW = $clog2(BANK_WORDS),
   localparam int unsigned SW = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cap_en,
   input  logic                 smp_valid,
   input  logic [DATA_W-1:0]    smp_data,
   input  logic                 irq_clr,
   input  logic                 ovr_clr,
   output logic [NUM_BANKS-1:0] bank_we,
   output logic [AW-1:0]        bank_addr,
   output logic [DATA_W-1:0]    bank_wdata,
   output logic                 irq,
   output logic [SW-1:0]        done_bank,
   output logic                 overrun
);
   logic          acc;
   logic [SW-1:0] cur_bank;
   logic [AW-1:0] cur_word;
   logic          last_word;

   assign acc = cap_en && smp_valid;

   adc_cap_addr_gen #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_WORDS(BANK_WORDS),
      .ADDR_W    (ADDR_W)
   ) u_addr (
      .clk      (clk),
      .rst      (rst),
      .adv      (acc),
      .cur_bank (cur_bank),
      .cur_word (cur_word),
      .last_word(last_word)
   );

   adc_cap_wr_port #(
      .DATA_W   (DATA_W),
      .NUM_BANKS(NUM_BANKS),
      .AW       (AW),
      .SW       (SW),
      .REG_OUT  (REG_OUT)
   ) u_wr (
      .clk     (clk),
      .rst     (rst),
      .acc     (acc),
      .sel_bank(cur_bank),
      .sel_word(cur_word),
      .din     (smp_data),
      .we      (bank_we),
      .addr    (bank_addr),
      .wdata   (bank_wdata)
   );

   adc_cap_irq_ctrl #(
      .SW(SW)
   ) u_irq (
      .clk      (clk),
      .rst      (rst),
      .fill_evt (acc && last_word),
      .fill_idx (cur_bank),
      .irq_clr  (irq_clr),
      .ovr_clr  (ovr_clr),
      .irq      (irq),
      .done_bank(done_bank),
      .overrun  (overrun)
   );
endmodule

// File: rtl/adc_bank_capture_chk.sv
module adc_bank_capture_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_BANKS  = 4,
   parameter int unsigned BANK_WORDS = 4096,
   parameter bit          REG_OUT    = 1'b1,
   localparam int unsigned AW = $clog2(BANK_WORDS),
   localparam int unsigned SW = $clog2(NUM_BANKS)
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 cap_en,
   input logic                 smp_valid,
   input logic [DATA_W-1:0]    smp_data,
   input logic                 irq_clr,
   input logic                 ovr_clr,
   input logic [NUM_BANKS-1:0] bank_we,
   input logic [AW-1:0]        bank_addr,
   input logic [DATA_W-1:0]    bank_wdata,
   input logic                 irq,
   input logic [SW-1:0]        done_bank,
   input logic                 overrun
);
   AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(bank_we)); // R3

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (irq && !irq_clr) |=> irq); // R6

   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (overrun && !ovr_clr) |=> overrun); // R7

   AST_OVR_NEEDS_IRQ: assert property (@(posedge clk) disable iff (rst)
      $rose(overrun) |-> $past(irq)); // R7

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!irq && !overrun && bank_we == '0)); // R8

   if (REG_OUT) begin : g_reg_chk
      AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
         (cap_en && smp_valid) |=> (bank_we != '0 && bank_wdata == $past(smp_data))); // R1

      AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (rst)
         !(cap_en && smp_valid) |=> (bank_we == '0)); // R9

      AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
         ((bank_we != '0) && $past(bank_we != '0)) |-> (bank_addr == AW'($past(bank_addr) + 1'b1))); // R2

      AST_IRQ_ON_LAST: assert property (@(posedge clk) disable iff (rst)
         $rose(irq) |-> ((&bank_addr) && bank_we[done_bank])); // R5
   end
endmodule

bind adc_bank_capture adc_bank_capture_chk #(
   .DATA_W    (DATA_W),
   .NUM_BANKS (NUM_BANKS),
   .BANK_WORDS(BANK_WORDS),
   .REG_OUT   (REG_OUT)
) u_chk (.*);

// File: tb/test_adc_bank_capture.sv
module test_adc_bank_capture;
   localparam int WORDS = 4096;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cap_en = 1'b0;
   logic        smp_valid = 1'b0;
   logic [31:0] smp_data = '0;
   logic        irq_clr = 1'b0;
   logic        ovr_clr = 1'b0;
   logic [3:0]  bank_we;
   logic [11:0] bank_addr;
   logic [31:0] bank_wdata;
   logic        irq;
   logic [1:0]  done_bank;
   logic        overrun;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // bench model
   int        m_cnt = 0;   // accepted samples since reset, mod 4*WORDS
   bit        m_irq = 0, m_ovr = 0;
   int        m_done = 0;
   int        seq = 0;

   always #5 clk = ~clk;

   adc_bank_capture i_adc_bank_capture (
      .clk(clk), .rst(rst), .cap_en(cap_en), .smp_valid(smp_valid),
      .smp_data(smp_data), .irq_clr(irq_clr), .ovr_clr(ovr_clr),
      .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
      .irq(irq), .done_bank(done_bank), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // One clock: drive inputs, advance model, check every output after the edge.
   task automatic step(input bit en, input bit vld, input bit ic, input bit oc);
      logic [31:0] d;
      bit acc, fill;
      int bank, word;
      logic [3:0] exp_we;
      d = 32'h5A00_0000 ^ (seq * 32'h0001_0003);
      seq++;
      @(negedge clk);
      cap_en = en; smp_valid = vld; smp_data = d; irq_clr = ic; ovr_clr = oc;
      acc  = en && vld;
      bank = m_cnt / WORDS;
      word = m_cnt % WORDS;
      fill = acc && (word == WORDS - 1);
      exp_we = acc ? (4'b0001 << bank) : 4'b0000;
      m_ovr = (fill && m_irq && !ic) || (m_ovr && !oc);
      m_irq = fill || (m_irq && !ic);
      if (fill) m_done = bank;
      if (acc) m_cnt = (m_cnt + 1) % (4 * WORDS);
      @(posedge clk);
      #1;
      chk(bank_we == exp_we, "R3 bank_we", 32'(bank_we), 32'(exp_we));
      if (acc) begin
         chk(bank_addr == 12'(word), "R2 bank_addr", 32'(bank_addr), 32'(word));
         chk(bank_wdata == d, "R1 bank_wdata", bank_wdata, d);
      end
      chk(irq == m_irq, "R5/R6 irq", 32'(irq), 32'(m_irq));
      chk(overrun == m_ovr, "R7 overrun", 32'(overrun), 32'(m_ovr));
      chk(done_bank == 2'(m_done), "R5 done_bank", 32'(done_bank), 32'(m_done));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; cap_en = 1'b0; smp_valid = 1'b0; irq_clr = 1'b0; ovr_clr = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      m_cnt = 0; m_irq = 0; m_ovr = 0; m_done = 0;
      chk(bank_we == 4'b0 && !irq && !overrun && done_bank == 2'd0,
          "R8 reset state", {bank_we, 2'b0, done_bank, 2'b0, irq, overrun}, 32'd0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step(1, 1, 0, 0);
   endtask

   task automatic t_reset_state();
      do_reset();
   endtask

   task automatic t_fill_first();
      run(WORDS - 1);
      chk(irq == 1'b0, "R5 irq quiet before last word", 32'(irq), 0);
      step(1, 1, 0, 0);
      chk(irq && done_bank == 2'd0, "R5 bank0 filled", {30'd0, done_bank} | 32'(irq) << 8, 32'h100);
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      chk(irq == 1'b1, "R6 irq sticky", 32'(irq), 1);
      step(0, 0, 1, 0);
      chk(irq == 1'b0, "R6 irq cleared", 32'(irq), 0);
   endtask

   task automatic t_gating();
      step(1, 1, 0, 0);                 // word 0 of bank 1
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
      chk(bank_we == 4'b0, "R9 enable low, no write", 32'(bank_we), 0);
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
      chk(bank_we == 4'b0, "R9 strobe low, no write", 32'(bank_we), 0);
      step(1, 1, 0, 0);
      chk(bank_addr == 12'd1 && bank_we == 4'b0010, "R9 resume at next word",
          {16'(bank_we), 4'd0, bank_addr}, {16'h2, 16'h1});
      for (int i = 0; i < 20; i++) step(1, (i % 3) != 0, 0, 0);  // sparse strobes
   endtask

   task automatic t_overrun();
      run(WORDS - (m_cnt % WORDS));     // finish bank 1
      chk(irq && done_bank == 2'd1 && !overrun, "R5 bank1 filled", 32'(done_bank), 1);
      run(WORDS);                       // bank 2 fills with irq pending
      chk(overrun == 1'b1 && done_bank == 2'd2, "R7 overrun set", 32'(overrun), 1);
      step(0, 0, 0, 0);
      chk(overrun == 1'b1, "R7 overrun held", 32'(overrun), 1);
      step(0, 0, 0, 1);
      chk(overrun == 1'b0, "R7 overrun cleared", 32'(overrun), 0);
      step(0, 0, 1, 0);
   endtask

   task automatic t_wrap();
      run(WORDS);                       // bank 3
      chk(irq && done_bank == 2'd3, "R4 bank3 filled", 32'(done_bank), 3);
      step(1, 1, 0, 0);
      chk(bank_we == 4'b0001 && bank_addr == 12'd0, "R4 wrap to bank0 word0",
          {16'(bank_we), 4'd0, bank_addr}, {16'h1, 16'h0});
   endtask

   task automatic t_clear_collide();
      run(WORDS - 2);                   // irq still set from bank 3
      step(1, 1, 1, 0);                 // last word of bank 0 with a clear
      chk(irq == 1'b1 && overrun == 1'b0, "R6 fill beats clear, no overrun",
          {31'd0, irq} << 4 | 32'(overrun), 32'h10);
      chk(done_bank == 2'd0, "R6 done_bank after collide", 32'(done_bank), 0);
   endtask

   task automatic t_reset_mid();
      run(17);
      do_reset();
      step(1, 1, 0, 0);
      chk(bank_we == 4'b0001 && bank_addr == 12'd0, "R8 restart at bank0 word0",
          {16'(bank_we), 4'd0, bank_addr}, {16'h1, 16'h0});
   endtask

   initial begin
      t_reset_state();
      t_fill_first();
      t_gating();
      t_overrun();
      t_wrap();
      t_clear_collide();
      t_reset_mid();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(150000 * 10);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule